// File: doc/BRIEF.md
# Line Sync Flywheel Regenerator

This block produces a clean horizontal sync from a digital sync input (taken from composite sync or from sync-on-green) whose line pulses may vanish, invert or slip while vertical retrace is in progress. All timing runs on one system clock. A local line timebase learns the incoming line period. It advances through 32 sub-steps per line and wraps once per line, which gives a local line edge. Each leading edge of the incoming sync that passes the tracking rules snaps this timebase back into phase.

A short, fixed delay after each local line edge, the block samples the incoming sync level. When the sync is low at that moment, the line is flagged missing. The tracking loop then opens: the measured period is frozen and the timebase keeps free-running at its last rate. At the same moment the output switches from the incoming sync to pulses generated from the local edge.

The incoming sync reaches the output through a longer delay than the sampling delay. This ordering lets the choice of source settle before the pulse appears, so the switch never clips or doubles a pulse. Coasting ends as soon as a line edge again finds the incoming sync present. If the coast window runs out first, the block drops into a re-lock state and snaps to the next incoming leading edge at any phase. Every output pulse has a fixed width. In composite output mode, each substituted pulse is instead half a line period long.

Top module: `line_sync_flywheel`

## Requirements
- R1: While reset is held and in the cycle after it is released, `sync_out`, `locked`, `coasting` and `miss` are all 0.
- R2: While not locked, each rising edge of `sync_in` is reproduced on `sync_out` with a fixed latency of OUT_DLY+2 clock cycles, counted from the cycle in which the input is first sampled high.
- R3: `locked` rises only after four consecutive incoming leading edges have each arrived within TOL clocks of the stored line period. The first legal period measured after reset is stored but does not count as one of the four unless it matches the nominal period.
- R4: A measured spacing between leading edges outside MIN_PER..MAX_PER clocks is neither stored nor counted toward lock. A train of such pulses leaves `locked` at 0.
- R5: While locked, if `sync_in` is low at the sampling point SAMPLE_DLY clocks after a local line edge, `miss` pulses for one cycle and `coasting` rises in the same cycle, while `locked` falls.
- R6: While coasting, a local pulse appears on `sync_out` in the same cycle in which the delayed incoming pulse would have appeared, so the output keeps its line period.
- R7: While coasting, a line edge that finds `sync_in` high returns the block to locked, and the output source goes back to the incoming sync.
- R8: When the coast window (COAST_LEN clocks) runs out, `coasting` falls with `locked` still 0 and local pulses continue on `sync_out`. The next incoming leading edge, at any phase, sets `locked`. The local timebase is then realigned to that edge, and no pulse remains at the old phase.
- R9: An incoming pulse that arrives after the sampling point of its line edge counts as missing. It starts coasting and is not passed to the output.
- R10: With `csync_mode` set, each locally substituted pulse lasts half the stored line period. Pulses taken from the incoming sync keep PULSE_W.
- R11: Each output pulse lasts exactly PULSE_W clocks unless R10 applies, and a trigger that arrives while a pulse is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Incoming sync, active high, possibly corrupted |
| csync_mode | input | 1 | 1: substituted pulses are half a line long |
| sync_out | output | 1 | Regenerated sync, active high, fixed width |
| locked | output | 1 | Tracking the incoming line timing |
| coasting | output | 1 | Loop open, output from local timebase |
| miss | output | 1 | One-cycle flag: line edge found no incoming pulse |

## Verification
The hardest state to reach from the ports is the re-lock state. It requires a lock, then a coast that lasts longer than the whole window with no incoming pulse landing on any line edge. Only after that does a returning pulse arrive at a phase that has nothing to do with the old one. The stimulus builds up to that point step by step: it locks on a 128-clock line, withholds five lines so that the 400-clock window runs out, and then resumes pulses 40 clocks off the old phase. The bench then checks that the stale local pulse comes first, that the new phase takes over, and that the old phase goes silent on the line after.

// File: rtl/line_sync_flywheel.sv
module line_sync_flywheel #(
  parameter int NOM_PER    = 3178,
  parameter int MIN_PER    = 1563,
  parameter int MAX_PER    = 6250,
  parameter int TOL        = 16,
  parameter int STEPS      = 32,
  parameter int SAMPLE_DLY = 12,
  parameter int OUT_DLY    = 18,
  parameter int PULSE_W    = 300,
  parameter int COAST_LEN  = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic csync_mode,
  output logic sync_out,
  output logic locked,
  output logic coasting,
  output logic miss
);

  localparam int PER_W  = $clog2(MAX_PER + 1) + 1;
  localparam int STEP_W = $clog2(STEPS);
  localparam int CNT_W  = $clog2(COAST_LEN + 1);
  localparam int WMAX   = (PULSE_W > MAX_PER / 2) ? PULSE_W : MAX_PER / 2;
  localparam int PC_W   = $clog2(WMAX + 1);

  typedef enum logic [1:0] {ST_ACQ, ST_TRACK, ST_COAST, ST_RELOCK} st_t;

  st_t               st;
  logic              s_q, s_q1;
  logic [PER_W-1:0]  pcnt, per_q, meas, diff;
  logic [PER_W:0]    acc, acc_n;
  logic [STEP_W-1:0] step;
  logic [1:0]        gcnt;
  logic [CNT_W-1:0]  ccnt;
  logic [OUT_DLY-1:0] ld, rd;
  logic [PC_W-1:0]   pc;
  logic              rise, legal, near, tick, le, align, chk, use_loc, trig, miss_q;

  assign rise  = s_q & ~s_q1;
  assign meas  = pcnt + 1'b1;
  assign legal = (meas >= PER_W'(MIN_PER)) && (meas <= PER_W'(MAX_PER));
  assign diff  = (meas > per_q) ? meas - per_q : per_q - meas;
  assign near  = legal && (diff <= PER_W'(TOL));

  assign acc_n = acc + (PER_W+1)'(STEPS);
  assign tick  = acc_n >= {1'b0, per_q};
  assign le    = tick && (step == STEP_W'(STEPS - 1));

  assign align = rise && ((st == ST_ACQ) || (st == ST_RELOCK) || ((st == ST_TRACK) && near));

  assign chk     = ld[SAMPLE_DLY-1];
  assign use_loc = (st == ST_COAST) || (st == ST_RELOCK);
  assign trig    = use_loc ? ld[OUT_DLY-1] : rd[OUT_DLY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q  <= 1'b0;
      s_q1 <= 1'b0;
      pcnt <= '1;
    end else begin
      s_q  <= sync_in;
      s_q1 <= s_q;
      if (rise)            pcnt <= '0;
      else if (pcnt != '1) pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q <= PER_W'(NOM_PER);
      acc   <= '0;
      step  <= '0;
    end else begin
      if (align && legal) per_q <= meas;
      if (align) begin
        acc  <= '0;
        step <= '0;
      end else if (tick) begin
        acc  <= acc_n - {1'b0, per_q};
        step <= step + 1'b1;
      end else begin
        acc  <= acc_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld <= '0;
      rd <= '0;
    end else begin
      ld <= {ld[OUT_DLY-2:0], le};
      rd <= {rd[OUT_DLY-2:0], rise};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_ACQ;
      gcnt   <= '0;
      ccnt   <= '0;
      miss_q <= 1'b0;
    end else begin
      miss_q <= chk && !s_q && ((st == ST_TRACK) || (st == ST_COAST));
      case (st)
        ST_ACQ: if (rise) begin
          if (near) begin
            if (gcnt == 2'd3) begin
              st   <= ST_TRACK;
              gcnt <= '0;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end else begin
            gcnt <= '0;
          end
        end
        ST_TRACK: if (chk && !s_q) begin
          st   <= ST_COAST;
          ccnt <= CNT_W'(COAST_LEN);
        end
        ST_COAST: begin
          if (chk && s_q)       st <= ST_TRACK;
          else if (ccnt == '0)  st <= ST_RELOCK;
          else                  ccnt <= ccnt - 1'b1;
        end
        default: if (rise) st <= ST_TRACK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc <= '0;
    else if (pc != '0)
      pc <= pc - 1'b1;
    else if (trig)
      pc <= (use_loc && csync_mode) ? PC_W'(per_q >> 1) : PC_W'(PULSE_W);
  end

  assign sync_out = (pc != '0);
  assign locked   = (st == ST_TRACK);
  assign coasting = (st == ST_COAST);
  assign miss     = miss_q;

endmodule

// File: rtl/lsf_checker.sv
module lsf_checker #(
  parameter int PW   = 300,
  parameter int MAXP = 6250
) (
  input logic clk,
  input logic rst_n,
  input logic sync_in,
  input logic sync_out,
  input logic locked,
  input logic coasting,
  input logic miss
);

  localparam int WMAX = (PW > MAXP / 2) ? PW : MAXP / 2;

  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n)        run <= 0;
    else if (sync_out) run <= run + 1;
    else               run <= 0;
  end

  a_r3_lock_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sync_in, 2));

  a_r5_coast_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coasting) |-> miss);

  a_r5_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);

  a_r9_miss_saw_low: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !$past(sync_in, 2));

  a_r11_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (run < WMAX));

endmodule

bind line_sync_flywheel lsf_checker #(.PW(PULSE_W), .MAXP(MAX_PER)) u_lsf_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_out(sync_out),
  .locked(locked), .coasting(coasting), .miss(miss)
);

// File: tb/test_line_sync_flywheel.sv
module test_line_sync_flywheel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic csync_mode = 1'b0;
  logic sync_out, locked, coasting, miss;

  int checks = 0;
  int errs = 0;

  logic ob [0:511];
  logic lk [0:511];
  logic cs [0:511];
  logic ms [0:511];

  always #5 clk = ~clk;

  line_sync_flywheel #(
    .NOM_PER(100), .MIN_PER(64), .MAX_PER(256), .TOL(2), .STEPS(32),
    .SAMPLE_DLY(3), .OUT_DLY(6), .PULSE_W(10), .COAST_LEN(400)
  ) i_line_sync_flywheel (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .csync_mode(csync_mode),
    .sync_out(sync_out), .locked(locked), .coasting(coasting), .miss(miss)
  );

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_line(input int len, input int off, input bit present);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ob[i] = sync_out; lk[i] = locked; cs[i] = coasting; ms[i] = miss;
      if (present && i == off)      sync_in = 1'b1;
      if (present && i == off + 12) sync_in = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    expect_eq("R1 out in reset", sync_out, 0);
    expect_eq("R1 locked in reset", locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1 out after reset", sync_out, 0);
    expect_eq("R1 locked after reset", locked, 0);
    expect_eq("R1 coasting after reset", coasting, 0);
    expect_eq("R1 miss after reset", miss, 0);
  endtask

  task automatic t_range;
    for (int l = 0; l < 8; l++) begin
      run_line(300, 0, 1'b1);
      expect_eq("R4 no lock on long period", lk[200], 0);
    end
    expect_eq("R2 passthrough not before latency", ob[7], 0);
    expect_eq("R2 passthrough at latency", ob[8], 1);
    expect_eq("R11 width last cycle", ob[17], 1);
    expect_eq("R11 width ends", ob[18], 0);
  endtask

  task automatic t_lock;
    for (int l = 1; l <= 6; l++) begin
      run_line(128, 0, 1'b1);
      expect_eq("R3 lock after four good edges", lk[20], (l == 6) ? 1 : 0);
    end
    run_line(128, 0, 1'b1);
    expect_eq("R3 stays locked", lk[20], 1);
    expect_eq("R3 no miss while locked", ms[5], 0);
  endtask

  task automatic t_coast_return;
    run_line(128, 0, 1'b0);
    expect_eq("R5 miss flagged", ms[5], 1);
    expect_eq("R5 miss single cycle", ms[6], 0);
    expect_eq("R5 coasting", cs[20], 1);
    expect_eq("R5 unlocked while coasting", lk[20], 0);
    expect_eq("R6 substitute not early", ob[7], 0);
    expect_eq("R6 substitute on time", ob[8], 1);
    expect_eq("R11 substitute width", ob[17], 1);
    expect_eq("R11 substitute ends", ob[18], 0);
    run_line(128, 0, 1'b1);
    expect_eq("R7 coast ends", cs[20], 0);
    expect_eq("R7 relocked", lk[20], 1);
    expect_eq("R7 no miss on return", ms[5], 0);
    expect_eq("R7 output pulse", ob[8], 1);
    run_line(128, 0, 1'b1);
  endtask

  task automatic t_late;
    run_line(128, 5, 1'b1);
    expect_eq("R9 late pulse flagged", ms[5], 1);
    expect_eq("R9 late pulse coasts", cs[20], 1);
    expect_eq("R9 substitute on time", ob[8], 1);
    expect_eq("R9 late pulse not passed", ob[19], 0);
    run_line(128, 0, 1'b1);
    expect_eq("R9 recovery locked", lk[20], 1);
    run_line(128, 0, 1'b1);
  endtask

  task automatic t_csync;
    csync_mode = 1'b1;
    run_line(128, 0, 1'b0);
    expect_eq("R10 half line pulse start", ob[8], 1);
    expect_eq("R10 half line pulse last", ob[71], 1);
    expect_eq("R10 half line pulse ends", ob[72], 0);
    run_line(128, 0, 1'b1);
    expect_eq("R10 incoming keeps width", ob[17], 1);
    expect_eq("R10 incoming width ends", ob[18], 0);
    csync_mode = 1'b0;
    run_line(128, 0, 1'b1);
  endtask

  task automatic t_expire;
    for (int l = 0; l < 5; l++) begin
      run_line(128, 0, 1'b0);
      expect_eq("R8 local pulses continue", ob[8], 1);
      if (l == 1) expect_eq("R8 coasting inside window", cs[20], 1);
      if (l == 4) begin
        expect_eq("R8 window expired", cs[20], 0);
        expect_eq("R8 not locked after expiry", lk[20], 0);
      end
    end
    run_line(128, 40, 1'b1);
    expect_eq("R8 stale local pulse", ob[8], 1);
    expect_eq("R8 new phase not early", ob[47], 0);
    expect_eq("R8 new phase pulse", ob[48], 1);
    expect_eq("R8 relock on any phase", lk[60], 1);
    run_line(128, 40, 1'b1);
    expect_eq("R8 old phase silent", ob[8], 0);
    expect_eq("R8 new phase held", ob[48], 1);
    expect_eq("R8 still locked", lk[60], 1);
    expect_eq("R8 no miss at new phase", ms[45], 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_range();
    t_lock();
    t_coast_return();
    t_late();
    t_csync();
    t_expire();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule